// File: doc/BRIEF.md
# Configurable four-input logic element

This block is the smallest programmable unit of a logic array. It holds a sixteen-entry truth table that is addressed by four logic inputs, so any Boolean function of those inputs can be realised by loading the right table. The chosen table bit can reach the output directly for combinational use, or pass through a state flip-flop first so that the element behaves as one bit of a sequential circuit.

The table and the output-mode bit are loaded through a single-bit serial configuration path. While the load enable is high, one bit is shifted in on each rising clock edge and the state flip-flop is frozen. Once the load enable drops, the element runs its function. Routing and carry logic belong to the surrounding array.

Top module: `cfg_logic_cell`

## Requirements
- R1: A synchronous active-high reset clears all 16 table bits, selects registered mode and clears the state flip-flop, so `cell_out` reads 0 after reset for every input pattern.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into a 17-bit configuration chain. The chain takes 17 bits, least significant first: the first bit becomes table entry 0, the sixteenth bit becomes entry 15, and the seventeenth bit is the mode bit.
- R3: The table address is `lin`, with `lin[0]` as its least significant bit, so pattern 4'b0000 selects entry 0 and pattern 4'b1111 selects entry 15.
- R4: With mode bit 1 (bypass), `cell_out` equals the selected table entry and follows changes on `lin` in the same cycle, without waiting for a clock edge.
- R5: With mode bit 0 (registered), `cell_out` shows the table entry that was selected at the previous rising edge on which `cfg_en` and `rst` were low. It does not change when `lin` changes between edges.
- R6: While `cfg_en` is high, the state flip-flop keeps its value, so in registered mode `cell_out` holds steady during a reload.
- R7: The reset acts only at a rising edge. Raising `rst` between edges leaves `cell_out` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable; also freezes the state flip-flop |
| cfg_din | input | 1 | Serial configuration data, least significant bit first |
| lin | input | 4 | Logic inputs that form the table address |
| cell_out | output | 1 | Element output, registered or bypassed |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `cfg_en`, `cfg_din` and `lin` are driven to known values whenever reset is low. Given that, the history they look at always starts from a known state. The bench changes every input on the falling edge and holds reset for several cycles at the start. It sweeps all sixteen input patterns for a four-input AND, for a parity function and for single-entry tables. It also loops the output back into an input to build a toggle, and it reloads the configuration while the state flip-flop holds a 1.

// File: rtl/cle_pkg.sv
package cle_pkg;
    localparam int LUT_K   = 4;
    localparam int TBL_W   = 1 << LUT_K;
    localparam int CHAIN_W = TBL_W + 1;

    typedef enum logic {
        OUT_REG  = 1'b0,
        OUT_COMB = 1'b1
    } out_sel_e;

    typedef struct packed {
        out_sel_e               sel;
        logic [TBL_W-1:0]       tbl;
    } cell_cfg_t;

    function automatic cell_cfg_t unpack_cfg(input logic [CHAIN_W-1:0] w);
        return cell_cfg_t'(w);
    endfunction
endpackage

// File: rtl/cle_cfg_chain.sv
module cle_cfg_chain #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (shift_en)
            word <= {din, word[W-1:1]};
    end
endmodule

// File: rtl/cle_lut_mux.sv
module cle_lut_mux #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      addr,
    output logic              y
);
    localparam int LEAVES = 1 << K;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] tree;

    genvar d, m, i;
    generate
        for (i = 0; i < LEAVES; i++) begin : g_leaf
            assign tree[LEAVES-1+i] = tbl[i];
        end
        for (d = 0; d < K; d++) begin : g_depth
            for (m = 0; m < (1 << d); m++) begin : g_node
                localparam int N = (1 << d) - 1 + m;
                assign tree[N] = addr[K-1-d] ? tree[2*N+2] : tree[2*N+1];
            end
        end
    endgenerate

    assign y = tree[0];
endmodule

// File: rtl/cle_state_reg.sv
module cle_state_reg (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (!hold)
            q <= d;
    end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import cle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] lin,
    output logic             cell_out
);
    logic [CHAIN_W-1:0] cfg_word;
    cell_cfg_t          cfg;
    logic               lut_bit;
    logic               state_q;

    cle_cfg_chain #(.W(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .word     (cfg_word)
    );

    assign cfg = unpack_cfg(cfg_word);

    cle_lut_mux #(.K(LUT_K)) u_lut (
        .tbl  (cfg.tbl),
        .addr (lin),
        .y    (lut_bit)
    );

    cle_state_reg u_state (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_en),
        .d    (lut_bit),
        .q    (state_q)
    );

    always_comb begin
        if (cfg.sel == OUT_COMB)
            cell_out = lut_bit;
        else
            cell_out = state_q;
    end
endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_en,
    input logic        cfg_din,
    input logic [3:0]  lin,
    input logic        cell_out,
    input logic [16:0] cfg_q,
    input logic        state_q
);
    // R2: serial shift, new bit enters at the top of the chain
    a_r2_chain_shift: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_q == {$past(cfg_din), $past(cfg_q[16:1])}));

    // R3 / R4: in bypass mode the output is the table bit indexed by lin
    a_r4_bypass_from_table: assert property (@(posedge clk) disable iff (rst)
        cfg_q[16] |-> (cell_out == cfg_q[lin]));

    // R5: outside configuration the state flop captures the indexed table bit
    a_r5_state_capture: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en) |=> (state_q == $past(cfg_q[lin])));

    // R6: the state flop is frozen during a configuration load
    a_r6_hold_in_cfg: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(state_q));

    // R5: registered mode shows the state flop
    a_r5_reg_output: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q[16]) |-> (cell_out == state_q));
endmodule

bind cfg_logic_cell cfg_logic_cell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .lin      (lin),
    .cell_out (cell_out),
    .cfg_q    (cfg_word),
    .state_q  (state_q)
);

// File: tb/cfg_logic_cell_test.sv
`timescale 1ns/1ps
module cfg_logic_cell_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] lin = 4'd0;
    logic       cell_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_logic_cell uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .lin      (lin),
        .cell_out (cell_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lin=%b got %b expected %b", req, lin, act, exp);
        end
    endtask

    // R2: 16 table bits LSB first, then the mode bit
    task automatic load_cfg(input logic [15:0] tbl, input logic mode);
        logic [16:0] w;
        w = {mode, tbl};
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic       prev;
        logic       q;
        logic [15:0] pat;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: after reset the table is zero and the mode is registered
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); lin = 4'(v);
            @(posedge clk); #1;
            chk("R1 reset output", cell_out, 1'b0);
        end

        // R4/R3: parity in bypass mode, same-cycle response
        load_cfg(16'h6996, 1'b1);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); lin = 4'(v); #1;
            chk("R4 bypass parity", cell_out, ^(4'(v)));
        end

        // R2/R3: single-entry tables prove bit ordering
        for (int e = 0; e < 16; e += 5) begin
            pat = 16'd1 << e;
            load_cfg(pat, 1'b1);
            for (int v = 0; v < 16; v++) begin
                @(negedge clk); lin = 4'(v); #1;
                chk("R2 chain order / R3 address", cell_out, (v == e));
            end
        end

        // R5: four-input AND in registered mode
        load_cfg(16'h8000, 1'b0);
        @(posedge clk); #1;
        prev = cell_out;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); lin = 4'(v); #1;
            chk("R5 holds between edges", cell_out, prev);
            @(posedge clk); #1;
            chk("R5 registered AND", cell_out, &(4'(v)));
            prev = cell_out;
        end

        // R5: toggle via external feedback, out = lin0 ^ lin1
        load_cfg(16'h6666, 1'b0);
        @(negedge clk); lin = 4'b0000;
        @(posedge clk); #1;
        q = cell_out;
        chk("R5 toggle start", q, 1'b0);
        for (int s = 0; s < 12; s++) begin
            logic t;
            t = (s % 3) != 2;
            @(negedge clk); lin = {2'b00, cell_out, t};
            @(posedge clk); #1;
            q = q ^ t;
            chk("R5 toggle step", cell_out, q);
        end

        // R6: state holds through a reload
        load_cfg(16'hFFFF, 1'b0);
        @(negedge clk); lin = 4'b1010;
        @(posedge clk); #1;
        chk("R6 preset state", cell_out, 1'b1);
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_din = 1'b0;
            @(posedge clk); #1;
            chk("R6 hold while loading", cell_out, 1'b1);
        end
        @(negedge clk); cfg_en = 1'b0; #1;
        chk("R6 hold after load", cell_out, 1'b1);
        @(posedge clk); #1;
        chk("R5 new zero table captured", cell_out, 1'b0);

        // R7: reset is synchronous
        load_cfg(16'hFFFF, 1'b0);
        @(posedge clk); #1;
        chk("R7 preset state", cell_out, 1'b1);
        @(negedge clk); rst = 1'b1; #1;
        chk("R7 no async clear", cell_out, 1'b1);
        @(posedge clk); #1;
        chk("R7 cleared at edge", cell_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 table cleared by reset", cell_out, 1'b0);

        finish_run();
    end
endmodule